// File: doc/BRIEF.md
# DMA Channel Interrupt Status Collector

This block gathers the completion and fault events of a bank of DMA transfer engines and turns them into software-visible state and one interrupt line. Every channel reports three single-cycle events: transfer terminated, channel halted, and address error. The block records each event in that channel's own status register. It also raises the channel's bit in a global pending register when the event calls for an interrupt. Halt and address-error events on any channel also set sticky summary bits in a global control register.

Software reads the registers through a simple read/write port and clears them by writing. A channel status register clears when software writes zeros to it. The pending register clears on a write of zero. The global summary bits clear only when the control register is written with them at zero. This means a handler can acknowledge a channel without losing the record that some channel faulted. The interrupt output is the OR of all pending bits, qualified by the global enable. The transfer engines themselves sit outside this block.

Top module: `dma_irq_collector`

## Requirements
- R1: After a synchronous active-high reset, every channel status and channel control register, the global control register and the pending register read as zero, and `irq_o` is low.
- R2: The channel status register sits at byte address channel*0x20 + 0x10. Bit 0 (channel enable) and bit 30 (8-word descriptor select) hold the written value. Bits 2 (halt), 3 (terminated) and 4 (address error) are loaded from the write, so a write of zero clears them.
- R3: A pulse on `ch_term_ev[i]`, `ch_halt_ev[i]` or `ch_aerr_ev[i]` sets bit 3, 2 or 4 of channel i's status in the next cycle. This holds even when software writes that register in the same cycle.
- R4: Pending bit i sets when channel i has a halt or address-error event. It also sets when channel i has a terminate event while its terminate-interrupt enable is 1. That enable is bit 1 of the channel control register at channel*0x20 + 0x14. A terminate event with the enable at 0 leaves the pending bit unchanged.
- R5: The pending register at 0x1004 holds one bit per channel, bit i for channel i. A write loads the written value, so a write of 0 clears it. A set condition in the same cycle as the write wins.
- R6: The global control register sits at 0x1000. Bit 0 (global enable) and bit 31 (fast-mode option) hold the written value. Bit 3 (halt summary) sets on any channel halt event. Bit 2 (address-error summary) sets on any channel address-error event. A write clears a summary bit that it writes as 0 and keeps one written as 1. An event in the same cycle wins.
- R7: Clearing a channel's status register or clearing the pending register leaves the global summary bits unchanged.
- R8: `irq_o` is a registered output. It equals global enable AND (OR of all pending bits), with the register values taken after the same clock edge.
- R9: `reg_rdata` and `reg_rvalid` are valid one cycle after `reg_rd`. Addresses that hit no register read as zero and ignore writes. These include channel slots at or above the channel count and global offset 0x1008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 13 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| reg_rvalid | output | 1 | Read data valid |
| ch_term_ev | input | 32 | Per-channel transfer-terminated event pulses |
| ch_halt_ev | input | 32 | Per-channel halt event pulses |
| ch_aerr_ev | input | 32 | Per-channel address-error event pulses |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that events win over simultaneous writes in each channel's status. They also check that pending bits set by an event are present one cycle later, that pending bits persist without a write, and that summary bits stay set without a control write. Two more cycle checks: the interrupt stays low while the global enable is clear, and at most one channel register is written per access. Some behaviours show only in the bench scenarios, where a reference model is compared through register reads. These are the separation between channel clear, pending clear and summary clear, the effect of the terminate-interrupt enable, and the read data layout of each register. Decoding of unmapped addresses is likewise covered only there.

// File: rtl/dic_pkg.sv
package dic_pkg;
  // channel status bit positions
  localparam int CS_EN   = 0;
  localparam int CS_HALT = 2;
  localparam int CS_TERM = 3;
  localparam int CS_AERR = 4;
  localparam int CS_D8   = 30;
  // channel control bit positions
  localparam int CC_IE   = 1;
  // global control bit positions
  localparam int GC_EN   = 0;
  localparam int GC_AERR = 2;
  localparam int GC_HALT = 3;
  localparam int GC_FAST = 31;
  // offsets inside a channel slot
  localparam logic [4:0] OFF_CSTAT = 5'h10;
  localparam logic [4:0] OFF_CCTL  = 5'h14;
  // offsets inside the global window
  localparam int GOFF_CTRL = 'h000;
  localparam int GOFF_PEND = 'h004;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CSTAT,
    SEL_CCTL,
    SEL_GCTRL,
    SEL_GPEND
  } sel_e;
endpackage

// File: rtl/dic_regif.sv
module dic_regif
  import dic_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [ADDR_W-1:0]             reg_addr,
  output logic [NUM_CH-1:0]             wr_cstat,
  output logic [NUM_CH-1:0]             wr_cctl,
  output logic                          wr_gctrl,
  output logic                          wr_gpend,
  input  logic [NUM_CH-1:0]             en_v,
  input  logic [NUM_CH-1:0]             d8_v,
  input  logic [NUM_CH-1:0]             halt_v,
  input  logic [NUM_CH-1:0]             term_v,
  input  logic [NUM_CH-1:0]             aerr_v,
  input  logic [NUM_CH-1:0]             ie_v,
  input  logic                          g_en,
  input  logic                          g_fast,
  input  logic                          g_halt,
  input  logic                          g_aerr,
  input  logic [NUM_CH-1:0]             pend,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic                          reg_rvalid
);
  localparam int SLOT_W = ADDR_W - 6;
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [SLOT_W:0]   NUM_CH_L = (SLOT_W+1)'(NUM_CH);
  localparam logic [ADDR_W-2:0] G_CTRL   = (ADDR_W-1)'(GOFF_CTRL);
  localparam logic [ADDR_W-2:0] G_PEND   = (ADDR_W-1)'(GOFF_PEND);

  logic [SLOT_W-1:0] ch_slot;
  logic [CH_W-1:0]   ch_idx;
  sel_e              sel;
  logic [DATA_W-1:0] rd_word;

  assign ch_slot = reg_addr[ADDR_W-2:5];
  assign ch_idx  = ch_slot[CH_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (reg_addr[ADDR_W-1]) begin
      if (reg_addr[ADDR_W-2:0] == G_CTRL)      sel = SEL_GCTRL;
      else if (reg_addr[ADDR_W-2:0] == G_PEND) sel = SEL_GPEND;
    end else if ({1'b0, ch_slot} < NUM_CH_L) begin
      if (reg_addr[4:0] == OFF_CSTAT)      sel = SEL_CSTAT;
      else if (reg_addr[4:0] == OFF_CCTL)  sel = SEL_CCTL;
    end
  end

  assign wr_cstat = (reg_wr && sel == SEL_CSTAT) ? (NUM_CH'(1) << ch_idx) : '0;
  assign wr_cctl  = (reg_wr && sel == SEL_CCTL)  ? (NUM_CH'(1) << ch_idx) : '0;
  assign wr_gctrl = reg_wr && (sel == SEL_GCTRL);
  assign wr_gpend = reg_wr && (sel == SEL_GPEND);

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_CSTAT: begin
        rd_word[CS_EN]   = en_v[ch_idx];
        rd_word[CS_HALT] = halt_v[ch_idx];
        rd_word[CS_TERM] = term_v[ch_idx];
        rd_word[CS_AERR] = aerr_v[ch_idx];
        rd_word[CS_D8]   = d8_v[ch_idx];
      end
      SEL_CCTL:  rd_word[CC_IE] = ie_v[ch_idx];
      SEL_GCTRL: begin
        rd_word[GC_EN]   = g_en;
        rd_word[GC_AERR] = g_aerr;
        rd_word[GC_HALT] = g_halt;
        rd_word[GC_FAST] = g_fast;
      end
      SEL_GPEND: rd_word[NUM_CH-1:0] = pend;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      reg_rdata  <= reg_rd ? rd_word : '0;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R9
  AST_ONE_CHAN_WR: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_cstat | wr_cctl)); // R9
endmodule

// File: rtl/dic_chan_bank.sv
module dic_chan_bank
  import dic_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] wr_cstat,
  input  logic [NUM_CH-1:0] wr_cctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] ev_term,
  input  logic [NUM_CH-1:0] ev_halt,
  input  logic [NUM_CH-1:0] ev_aerr,
  output logic [NUM_CH-1:0] en_v,
  output logic [NUM_CH-1:0] d8_v,
  output logic [NUM_CH-1:0] halt_v,
  output logic [NUM_CH-1:0] term_v,
  output logic [NUM_CH-1:0] aerr_v,
  output logic [NUM_CH-1:0] ie_v,
  output logic [NUM_CH-1:0] pend_set
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  // every channel can see an event in the same cycle, so state is flops
  always_ff @(posedge clk) begin
    if (rst) begin
      en_v   <= '0;
      d8_v   <= '0;
      halt_v <= '0;
      term_v <= '0;
      aerr_v <= '0;
      ie_v   <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_cstat[i]) begin
          en_v[i]   <= wdata[CS_EN];
          d8_v[i]   <= wdata[CS_D8];
          halt_v[i] <= wdata[CS_HALT] | ev_halt[i];
          term_v[i] <= wdata[CS_TERM] | ev_term[i];
          aerr_v[i] <= wdata[CS_AERR] | ev_aerr[i];
        end else begin
          halt_v[i] <= halt_v[i] | ev_halt[i];
          term_v[i] <= term_v[i] | ev_term[i];
          aerr_v[i] <= aerr_v[i] | ev_aerr[i];
        end
        if (wr_cctl[i]) ie_v[i] <= wdata[CC_IE];
      end
    end
  end

  assign pend_set = (ev_term & ie_v) | ev_halt | ev_aerr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_TERM_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
      ev_term[g] |=> term_v[g]); // R3
    AST_AERR_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
      ev_aerr[g] |=> aerr_v[g]); // R3
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (wr_cstat[g] && !wdata[CS_HALT] && !ev_halt[g]) |=> !halt_v[g]); // R2
  end
endmodule

// File: rtl/dic_global.sv
module dic_global
  import dic_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_gctrl,
  input  logic              wr_gpend,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] pend_set,
  input  logic              any_halt,
  input  logic              any_aerr,
  output logic              g_en,
  output logic              g_fast,
  output logic              g_halt,
  output logic              g_aerr,
  output logic [NUM_CH-1:0] pend,
  output logic              irq_o
);
  logic              en_n, fast_n, halt_n, aerr_n;
  logic [NUM_CH-1:0] pend_n;
  logic              unused_wbits;
  assign unused_wbits = ^wdata;

  always_comb begin
    en_n   = wr_gctrl ? wdata[GC_EN]   : g_en;
    fast_n = wr_gctrl ? wdata[GC_FAST] : g_fast;
    halt_n = (wr_gctrl ? (g_halt & wdata[GC_HALT]) : g_halt) | any_halt;
    aerr_n = (wr_gctrl ? (g_aerr & wdata[GC_AERR]) : g_aerr) | any_aerr;
    pend_n = (wr_gpend ? wdata[NUM_CH-1:0] : pend) | pend_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g_en   <= 1'b0;
      g_fast <= 1'b0;
      g_halt <= 1'b0;
      g_aerr <= 1'b0;
      pend   <= '0;
      irq_o  <= 1'b0;
    end else begin
      g_en   <= en_n;
      g_fast <= fast_n;
      g_halt <= halt_n;
      g_aerr <= aerr_n;
      pend   <= pend_n;
      irq_o  <= en_n & (|pend_n);
    end
  end

  AST_PEND_SETS: assert property (@(posedge clk) disable iff (rst)
    (|pend_set) |=> ((pend & $past(pend_set)) == $past(pend_set))); // R4
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_gpend |=> ((pend & $past(pend)) == $past(pend))); // R5
  AST_HALT_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    any_halt |=> g_halt); // R6
  AST_SUMMARY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (g_halt && !wr_gctrl) |=> g_halt); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !g_en |-> !irq_o); // R8
endmodule

// File: rtl/dma_irq_collector.sv
module dma_irq_collector
  import dic_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic [NUM_CH-1:0] ch_term_ev,
  input  logic [NUM_CH-1:0] ch_halt_ev,
  input  logic [NUM_CH-1:0] ch_aerr_ev,
  output logic              irq_o
);
  logic [NUM_CH-1:0] wr_cstat, wr_cctl;
  logic              wr_gctrl, wr_gpend;
  logic [NUM_CH-1:0] en_v, d8_v, halt_v, term_v, aerr_v, ie_v, pend_set, pend;
  logic              g_en, g_fast, g_halt, g_aerr;

  dic_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .wr_cstat(wr_cstat), .wr_cctl(wr_cctl), .wr_gctrl(wr_gctrl), .wr_gpend(wr_gpend),
    .en_v(en_v), .d8_v(d8_v), .halt_v(halt_v), .term_v(term_v), .aerr_v(aerr_v),
    .ie_v(ie_v), .g_en(g_en), .g_fast(g_fast), .g_halt(g_halt), .g_aerr(g_aerr),
    .pend(pend), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  dic_chan_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .wr_cstat(wr_cstat), .wr_cctl(wr_cctl), .wdata(reg_wdata),
    .ev_term(ch_term_ev), .ev_halt(ch_halt_ev), .ev_aerr(ch_aerr_ev),
    .en_v(en_v), .d8_v(d8_v), .halt_v(halt_v), .term_v(term_v), .aerr_v(aerr_v),
    .ie_v(ie_v), .pend_set(pend_set)
  );

  dic_global #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_glob (
    .clk(clk), .rst(rst), .wr_gctrl(wr_gctrl), .wr_gpend(wr_gpend), .wdata(reg_wdata),
    .pend_set(pend_set), .any_halt(|ch_halt_ev), .any_aerr(|ch_aerr_ev),
    .g_en(g_en), .g_fast(g_fast), .g_halt(g_halt), .g_aerr(g_aerr),
    .pend(pend), .irq_o(irq_o)
  );
endmodule

// File: tb/dma_irq_collector_tb_top.sv
module dma_irq_collector_tb_top;
  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [NCH-1:0] ev_t = '0, ev_h = '0, ev_a = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state derived from the requirements
  logic [NCH-1:0] m_en, m_d8, m_halt, m_term, m_aerr, m_ie, m_pend;
  logic m_gen, m_fast, m_gh, m_ga;

  always #2 clk = ~clk;

  dma_irq_collector dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .ch_term_ev(ev_t), .ch_halt_ev(ev_h), .ch_aerr_ev(ev_a), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_en = '0; m_d8 = '0; m_halt = '0; m_term = '0; m_aerr = '0; m_ie = '0;
    m_pend = '0; m_gen = 0; m_fast = 0; m_gh = 0; m_ga = 0;
  endtask

  // 0 none, 1 chan status, 2 chan control, 3 global ctrl, 4 pending
  function automatic int decode(input logic [12:0] a);
    if (a[12]) begin
      if (a[11:0] == 12'h000) return 3;
      if (a[11:0] == 12'h004) return 4;
      return 0;
    end
    if (a[11:5] >= 7'(NCH)) return 0;
    if (a[4:0] == 5'h10) return 1;
    if (a[4:0] == 5'h14) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [12:0] a);
    logic [31:0] w = '0;
    int c = int'(a[11:5]);
    case (decode(a))
      1: begin w[0] = m_en[c]; w[2] = m_halt[c]; w[3] = m_term[c]; w[4] = m_aerr[c]; w[30] = m_d8[c]; end
      2: w[1] = m_ie[c];
      3: begin w[0] = m_gen; w[2] = m_ga; w[3] = m_gh; w[31] = m_fast; end
      4: w = m_pend;
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic model_step(input bit wr, input logic [12:0] a, input logic [31:0] d,
                            input logic [NCH-1:0] t, input logic [NCH-1:0] h, input logic [NCH-1:0] e);
    logic [NCH-1:0] pset = (t & m_ie) | h | e;
    int c = int'(a[11:5]);
    int k = wr ? decode(a) : 0;
    if (k == 1) begin
      m_en[c] = d[0]; m_d8[c] = d[30]; m_halt[c] = d[2]; m_term[c] = d[3]; m_aerr[c] = d[4];
    end
    if (k == 2) m_ie[c] = d[1];
    if (k == 3) begin
      m_gen = d[0]; m_fast = d[31]; m_gh = m_gh & d[3]; m_ga = m_ga & d[2];
    end
    if (k == 4) m_pend = d;
    m_halt = m_halt | h; m_term = m_term | t; m_aerr = m_aerr | e;
    m_gh = m_gh | (|h); m_ga = m_ga | (|e);
    m_pend = m_pend | pset;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input bit wr, input logic [12:0] a, input logic [31:0] d,
                     input logic [NCH-1:0] t, input logic [NCH-1:0] h, input logic [NCH-1:0] e);
    reg_wr = wr; reg_addr = a; reg_wdata = d; ev_t = t; ev_h = h; ev_a = e;
    @(posedge clk);
    model_step(wr, a, d, t, h, e);
    @(negedge clk);
    reg_wr = 0; ev_t = '0; ev_h = '0; ev_a = '0;
    chk("R8 irq", {31'b0, irq_o}, {31'b0, m_gen & (|m_pend)});
  endtask

  task automatic rd(input logic [12:0] a, input string req);
    reg_rd = 1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 0;
    chk({req, " rvalid"}, {31'b0, reg_rvalid}, 32'd1);
    chk(req, reg_rdata, exp_read(a));
  endtask

  function automatic logic [12:0] cs(input int c);  return 13'(c * 32 + 16); endfunction
  function automatic logic [12:0] cc(input int c);  return 13'(c * 32 + 20); endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'd0);
    rd(13'h1000, "R1 ctrl");
    rd(13'h1004, "R1 pend");
    rd(cs(0), "R1 cstat");
    rd(cc(31), "R1 cctl");

    // R6 enable and fast option
    cyc(1, 13'h1000, 32'h8000_0001, '0, '0, '0);
    rd(13'h1000, "R6 ctrl rw");
    chk("R6 literal", reg_rdata, 32'h8000_0001);

    // R2 status enable and descriptor select
    cyc(1, cs(4), 32'h4000_0001, '0, '0, '0);
    rd(cs(4), "R2 status rw");
    chk("R2 literal", reg_rdata, 32'h4000_0001);

    // R4 terminate with enable set -> pending and irq
    cyc(1, cc(3), 32'h2, '0, '0, '0);
    cyc(0, '0, '0, 32'h8, '0, '0);
    rd(cs(3), "R3 term bit");
    rd(13'h1004, "R4 pend term ie");
    chk("R8 literal irq", {31'b0, irq_o}, 32'd1);

    // R4 terminate without enable -> no pending
    cyc(0, '0, '0, 32'h20, '0, '0);
    rd(cs(5), "R3 term no ie");
    rd(13'h1004, "R4 no pend without ie");
    chk("R4 literal", reg_rdata, 32'h8);

    // R6 halt summary, R4 halt pends
    cyc(0, '0, '0, '0, 32'h80, '0);
    rd(13'h1000, "R6 halt summary");
    rd(13'h1004, "R4 halt pend");

    // R2/R7 channel clear keeps summary and pending
    cyc(1, cs(7), 32'h0, '0, '0, '0);
    rd(cs(7), "R2 clear");
    chk("R2 literal clr", reg_rdata, 32'h0);
    rd(13'h1000, "R7 summary after chan clear");
    rd(13'h1004, "R7 pend after chan clear");

    // R5 pending clear, R7 summary survives, R8 irq drops
    cyc(1, 13'h1004, 32'h0, '0, '0, '0);
    chk("R8 irq after clear", {31'b0, irq_o}, 32'd0);
    rd(13'h1000, "R7 summary after pend clear");

    // R6 write 1 keeps summary, write 0 clears
    cyc(1, 13'h1000, 32'h8000_0009, '0, '0, '0);
    rd(13'h1000, "R6 keep");
    cyc(1, 13'h1000, 32'h0000_0001, '0, '0, '0);
    rd(13'h1000, "R6 clear");
    chk("R6 literal clr", reg_rdata, 32'h1);

    // R3/R5/R6 events beat simultaneous writes
    cyc(1, cs(2), 32'h0, '0, '0, 32'h4);
    rd(cs(2), "R3 event wins");
    cyc(1, 13'h1004, 32'h0, '0, 32'h200, '0);
    rd(13'h1004, "R5 set wins");
    cyc(1, 13'h1000, 32'h1, '0, '0, 32'h1);
    rd(13'h1000, "R6 event wins");

    // R9 unmapped addresses
    cyc(1, 13'h0410, 32'hFFFF_FFFF, '0, '0, '0);
    rd(13'h0410, "R9 beyond channels");
    rd(13'h1008, "R9 global hole");
    rd(cs(0), "R9 no alias");

    // R8 enable gate
    cyc(1, 13'h1000, 32'h0, '0, '0, '0);
    chk("R8 gated", {31'b0, irq_o}, 32'd0);

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op = $urandom % 6;
      int c  = $urandom % NCH;
      logic [12:0] a;
      logic [31:0] d = $urandom;
      logic [NCH-1:0] t = $urandom & $urandom & $urandom;
      logic [NCH-1:0] h = $urandom & $urandom & $urandom & $urandom;
      logic [NCH-1:0] e = $urandom & $urandom & $urandom & $urandom;
      case (op)
        0: a = cs(c);
        1: a = cc(c);
        2: begin a = 13'h1000; d[0] = ($urandom % 4) != 0; end
        3: begin a = 13'h1004; d = d & $urandom; end
        default: a = 13'(($urandom % 2) ? 13'h0800 + c : 13'h1008);
      endcase
      cyc(($urandom % 3) != 0, a, d, t, h, e);
      if (it % 4 == 0) begin
        case ($urandom % 4)
          0: rd(cs(c), "R3 rand cstat");
          1: rd(cc(c), "R4 rand cctl");
          2: rd(13'h1000, "R6 rand ctrl");
          default: rd(13'h1004, "R5 rand pend");
        endcase
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule